// File: doc/BRIEF.md
# Clause 45 MDIO Management Responder

This block is the device side of a two-wire management link. It runs on the management clock and samples the data line on each rising edge. Once it has seen a long run of idle-high bits, it decodes indirect-addressing frames. An address frame loads a 16-bit register pointer for one management device number (MMD). A write frame passes the data word to an attached register file. A read frame fetches a word from that file and drives it back onto the shared line through an output enable.

The block answers only frames whose 5-bit port address equals the strap input. It keeps one pointer for each MMD number below `NUM_MMD`. The attached register file sees the selected MMD and pointer on `rf_mmd` and `rf_addr`. Writes arrive as a one-cycle `rf_we` pulse. During the cycle in which `rf_re` is high, the file must present read data combinationally on `rf_rdata`.

Top module: `mdio_c45_responder`

## Requirements
- R1: A frame is recognised only after at least `PRE_LEN` (32) consecutive 1 bits sampled in the idle state. Any 0 sampled before that count is reached clears the count, so 31 ones followed by a frame, or a run of ones broken by a 0, produce no action. Runs longer than 32 are accepted.
- R2: After the preamble, the two start bits must be 0,0. If the second start bit is 1, the frame is abandoned and a fresh preamble is needed.
- R3: Opcode (2 bits), port address (5 bits) and MMD number (5 bits) follow the start bits in that order, each MSB first. When the port address differs from `phy_addr_strap`, the block makes no pointer update, gives no `rf_we` or `rf_re` pulse and does not drive the line.
- R4: Opcode 00 stores the 16-bit field (MSB first) as the pointer of the addressed MMD. MMD numbers at or above `NUM_MMD` are ignored by every opcode.
- R5: Opcode 01 gives exactly one `rf_we` pulse, in the cycle after the last data bit is sampled. During that pulse `rf_wdata` holds the data field, `rf_addr` holds the MMD's pointer and `rf_mmd` holds the MMD number.
- R6: Opcode 11 gives one `rf_re` pulse in the cycle after the last MMD bit. The block leaves the line undriven for the first turnaround bit, drives 0 for the second, and then drives the 16 data bits MSB first.
- R7: `mdio_oe` is high for exactly 17 bit times per answered read and is released right after the last data bit. Address and write frames never raise it.
- R8: Pointers never change on reads or writes. Repeated accesses use the same pointer.
- R9: An address or write frame whose turnaround is not 1,0 is discarded, with no pointer update and no `rf_we`.
- R10: Opcode 10 causes no access and no drive.
- R11: After reset `mdio_oe`, `rf_we` and `rf_re` are low, every pointer is 0 and `rf_mmd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| phy_addr_strap | input | 5 | Port address this responder answers to |
| mdio_i | input | 1 | Sampled level of the shared data line |
| mdio_o | output | 1 | Level driven when the enable is high |
| mdio_oe | output | 1 | Tri-state enable for the data line |
| rf_we | output | 1 | One-cycle register-file write strobe |
| rf_re | output | 1 | One-cycle register-file read strobe |
| rf_mmd | output | 5 | MMD number of the current access |
| rf_addr | output | 16 | Pointer held for that MMD |
| rf_wdata | output | 16 | Write data |
| rf_rdata | input | 16 | Read data, valid while `rf_re` is high |

## Verification
The bench goes after the preamble edge cases: 31 ones, a run of ones broken by a single 0, and an over-long run. A counter that is never cleared, or that is off by one, would accept the first two or reject the third. It sends a bad start pair and then a frame with a corrupt turnaround; a decoder that ignored either field would write anyway. Each read is sampled bit by bit and the enable-high time is counted. Driving one bit early would collide with the host on the first turnaround bit, and releasing one bit late would hold the line past the frame. Reads and writes repeated to one MMD, foreign port addresses and out-of-range MMD numbers show whether a pointer moves when it should not.

// File: rtl/mdio_c45_pkg.sv
// Shared types and field sizes for the Clause 45 management responder.
// Assumes frames carry 2 opcode, 5 port, 5 MMD, 2 turnaround and 16 data bits.
package mdio_c45_pkg;
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_START2 = 2'd1,
        ST_FRAME  = 2'd2
    } mdio_st_e;

    localparam logic [1:0] OPC_ADDR  = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b11;

    localparam int HDR_BITS  = 12;
    localparam int TA_BITS   = 2;
    localparam int DATA_BITS = 16;
    localparam int FRAME_BITS = HDR_BITS + TA_BITS + DATA_BITS;
endpackage

// File: rtl/mdio_pre_det.sv
// Preamble detector: counts consecutive 1 samples while enabled.
// Assumes en is high only while the parent is hunting for a frame start;
// dropping en clears the count so every frame needs a fresh preamble.
module mdio_pre_det #(
    parameter int PRE_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bit_i,
    output logic seen_o
);
    localparam int CNT_W = $clog2(PRE_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PRE_LEN);

    logic [CNT_W-1:0] run_cnt;

    // Count ones up to the saturation value; any zero or disable restarts.
    always_ff @(posedge clk) begin : run_cnt_p
        if (!rst_n || !en || !bit_i) begin
            run_cnt <= '0;
        end else if (run_cnt != CNT_MAX) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign seen_o = (run_cnt == CNT_MAX);
endmodule

// File: rtl/mdio_addr_bank.sv
// Per-MMD 16-bit pointer storage with one write and one read port.
// Assumes the caller only writes indices below NUM_MMD; reads of other
// indices return zero.
module mdio_addr_bank #(
    parameter int NUM_MMD = 4,
    parameter int PTR_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [4:0]       wr_idx,
    input  logic [PTR_W-1:0] wr_data,
    input  logic [4:0]       rd_idx,
    output logic [PTR_W-1:0] rd_data
);
    logic [PTR_W-1:0] ptr_q [NUM_MMD];

    // Clear all pointers on reset; load the selected one on a write.
    always_ff @(posedge clk) begin : ptr_p
        for (int i = 0; i < NUM_MMD; i++) begin
            if (!rst_n) begin
                ptr_q[i] <= '0;
            end else if (wr_en && (wr_idx == 5'(i))) begin
                ptr_q[i] <= wr_data;
            end
        end
    end

    // Select the pointer of the requested MMD.
    always_comb begin : rd_mux_p
        rd_data = '0;
        for (int i = 0; i < NUM_MMD; i++) begin
            if (rd_idx == 5'(i)) rd_data = ptr_q[i];
        end
    end
endmodule

// File: rtl/mdio_c45_responder.sv
// Device-side Clause 45 management responder.
// Samples mdio_i on rising mdc, decodes address/write/read frames for the
// strapped port address, keeps one pointer per MMD and drives read data
// back with tri-state control. Assumes rf_rdata is valid combinationally
// while rf_re is high, and NUM_MMD is at most 32.
module mdio_c45_responder
    import mdio_c45_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int NUM_MMD = 4
) (
    input  logic        mdc,
    input  logic        rst_n,
    input  logic [4:0]  phy_addr_strap,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        rf_we,
    output logic        rf_re,
    output logic [4:0]  rf_mmd,
    output logic [15:0] rf_addr,
    output logic [15:0] rf_wdata,
    input  logic [15:0] rf_rdata
);
    localparam int CNT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] IDX_HDR_LAST = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] IDX_TA1      = CNT_W'(HDR_BITS);
    localparam logic [CNT_W-1:0] IDX_TA2      = CNT_W'(HDR_BITS + 1);
    localparam logic [CNT_W-1:0] IDX_LAST     = CNT_W'(FRAME_BITS - 1);

    mdio_st_e             state;
    logic [CNT_W-1:0]     bit_cnt;
    logic [HDR_BITS-2:0]  hdr_sr;
    logic [DATA_BITS-2:0] rx_sr;
    logic [DATA_BITS-1:0] tx_sr;
    logic [1:0]           op_q;
    logic [4:0]           mmd_q;
    logic                 hit_q;
    logic                 ta1_q;
    logic                 ta_ok_q;
    logic                 pre_seen;

    logic [HDR_BITS-1:0]  hdr_next;
    logic [DATA_BITS-1:0] rx_next;
    logic                 hit_now;
    logic                 at_hdr_last;
    logic                 at_last;
    logic                 commit_ok;
    logic                 ptr_we;
    logic                 rd_active;

    assign hdr_next    = {hdr_sr, mdio_i};
    assign rx_next     = {rx_sr, mdio_i};
    assign hit_now     = (hdr_next[9:5] == phy_addr_strap) &&
                         ({1'b0, hdr_next[4:0]} < 6'(NUM_MMD));
    assign at_hdr_last = (state == ST_FRAME) && (bit_cnt == IDX_HDR_LAST);
    assign at_last     = (state == ST_FRAME) && (bit_cnt == IDX_LAST);
    assign commit_ok   = at_last && hit_q && ta_ok_q;
    assign ptr_we      = commit_ok && (op_q == OPC_ADDR);
    assign rd_active   = hit_q && (op_q == OPC_READ);

    mdio_pre_det #(.PRE_LEN(PRE_LEN)) u_pre (
        .clk    (mdc),
        .rst_n  (rst_n),
        .en     (state == ST_HUNT),
        .bit_i  (mdio_i),
        .seen_o (pre_seen)
    );

    mdio_addr_bank #(.NUM_MMD(NUM_MMD), .PTR_W(16)) u_bank (
        .clk     (mdc),
        .rst_n   (rst_n),
        .wr_en   (ptr_we),
        .wr_idx  (mmd_q),
        .wr_data (rx_next),
        .rd_idx  (mmd_q),
        .rd_data (rf_addr)
    );

    // Frame sequencer: start detection, header/turnaround/data capture.
    always_ff @(posedge mdc) begin : seq_p
        if (!rst_n) begin
            state   <= ST_HUNT;
            bit_cnt <= '0;
            hdr_sr  <= '0;
            rx_sr   <= '0;
            op_q    <= OPC_ADDR;
            mmd_q   <= '0;
            hit_q   <= 1'b0;
            ta1_q   <= 1'b0;
            ta_ok_q <= 1'b0;
        end else begin
            case (state)
                ST_HUNT: begin
                    if (!mdio_i && pre_seen) state <= ST_START2;
                end
                ST_START2: begin
                    if (!mdio_i) begin
                        state   <= ST_FRAME;
                        bit_cnt <= '0;
                    end else begin
                        state <= ST_HUNT;
                    end
                end
                ST_FRAME: begin
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt <= IDX_HDR_LAST) hdr_sr <= hdr_next[HDR_BITS-2:0];
                    if (bit_cnt == IDX_HDR_LAST) begin
                        hit_q <= hit_now;
                        if (hit_now) begin
                            op_q  <= hdr_next[11:10];
                            mmd_q <= hdr_next[4:0];
                        end
                    end
                    if (bit_cnt == IDX_TA1) ta1_q <= mdio_i;
                    if (bit_cnt == IDX_TA2) ta_ok_q <= ta1_q && !mdio_i;
                    if (bit_cnt > IDX_TA2) rx_sr <= rx_next[DATA_BITS-2:0];
                    if (bit_cnt == IDX_LAST) state <= ST_HUNT;
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

    // Register-file strobes: read after the header, write after the data.
    always_ff @(posedge mdc) begin : strobe_p
        if (!rst_n) begin
            rf_we    <= 1'b0;
            rf_re    <= 1'b0;
            rf_wdata <= '0;
        end else begin
            rf_re <= at_hdr_last && hit_now && (hdr_next[11:10] == OPC_READ);
            rf_we <= commit_ok && (op_q == OPC_WRITE);
            if (commit_ok && (op_q == OPC_WRITE)) rf_wdata <= rx_next;
        end
    end

    // Line driver: zero on the second turnaround bit, then data MSB first.
    always_ff @(posedge mdc) begin : drive_p
        if (!rst_n) begin
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
            tx_sr   <= '0;
        end else if ((state == ST_FRAME) && (bit_cnt == IDX_TA1) && rd_active) begin
            mdio_oe <= 1'b1;
            mdio_o  <= 1'b0;
            tx_sr   <= rf_rdata;
        end else if (at_last) begin
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
        end else if (mdio_oe) begin
            mdio_o <= tx_sr[DATA_BITS-1];
            tx_sr  <= {tx_sr[DATA_BITS-2:0], 1'b0};
        end
    end

    assign rf_mmd = mmd_q;
endmodule

// File: rtl/mdio_c45_responder_chk.sv
// Protocol checker for the management responder, bound to every instance.
// Assumes a synchronous active-low reset held for at least two cycles.
module mdio_c45_responder_chk (
    input logic        mdc,
    input logic        rst_n,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        rf_we,
    input logic        rf_re,
    input logic [15:0] rf_addr
);
    logic [5:0] oe_run;

    // Length of the current run of enabled bit times, saturating.
    always_ff @(posedge mdc) begin : oe_run_p
        if (!rst_n || !mdio_oe) begin
            oe_run <= '0;
        end else if (oe_run != 6'h3f) begin
            oe_run <= oe_run + 1'b1;
        end
    end

    // R6
    first_bit_zero_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o);

    // R6
    read_then_drive_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        rf_re |=> $rose(mdio_oe));

    // R7
    oe_window_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        $fell(mdio_oe) |-> (oe_run == 6'd17));

    // R5
    we_single_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        rf_we |=> !rf_we);

    // R7
    no_write_in_read_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        mdio_oe |-> !rf_we);

    // R8
    ptr_hold_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe)) |-> $stable(rf_addr));
endmodule

bind mdio_c45_responder mdio_c45_responder_chk u_chk (
    .mdc     (mdc),
    .rst_n   (rst_n),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .rf_we   (rf_we),
    .rf_re   (rf_re),
    .rf_addr (rf_addr)
);

// File: tb/mdio_c45_responder_tb.sv
module mdio_c45_responder_tb;
    localparam int         NUM_MMD = 4;
    localparam logic [4:0] STRAP   = 5'h0B;
    localparam int         NV      = 14;

    // Vector: {op[29:28], port[27:23], mmd[22:18], ta[17:16], data[15:0]}
    localparam logic [29:0] VEC [NV] = '{
        {2'b00, 5'h0B, 5'd1, 2'b10, 16'h1234},
        {2'b01, 5'h0B, 5'd1, 2'b10, 16'hBEEF},
        {2'b11, 5'h0B, 5'd1, 2'b10, 16'h0000},
        {2'b11, 5'h0B, 5'd1, 2'b10, 16'h0000},
        {2'b00, 5'h0B, 5'd3, 2'b10, 16'hFFFF},
        {2'b11, 5'h0B, 5'd3, 2'b10, 16'h0000},
        {2'b00, 5'h0C, 5'd1, 2'b10, 16'hAAAA},
        {2'b01, 5'h0C, 5'd1, 2'b10, 16'h5555},
        {2'b11, 5'h0B, 5'd1, 2'b10, 16'h0000},
        {2'b00, 5'h0B, 5'd1, 2'b11, 16'h0F0F},
        {2'b01, 5'h0B, 5'd1, 2'b00, 16'h1111},
        {2'b10, 5'h0B, 5'd1, 2'b10, 16'h0000},
        {2'b00, 5'h0B, 5'd5, 2'b10, 16'h7777},
        {2'b01, 5'h0B, 5'd5, 2'b10, 16'h2222}
    };

    logic mdc = 1'b0;
    always #4 mdc = ~mdc;

    logic        rst_n    = 1'b0;
    logic        host_oe  = 1'b0;
    logic        host_val = 1'b1;
    logic        mdio_o, mdio_oe, rf_we, rf_re;
    logic [4:0]  rf_mmd;
    logic [15:0] rf_addr, rf_wdata, rf_rdata;
    logic        line;

    function automatic logic [15:0] rf_model(logic [15:0] a, logic [4:0] m);
        return a ^ 16'hA5C3 ^ {11'd0, m};
    endfunction

    assign line     = mdio_oe ? mdio_o : (host_oe ? host_val : 1'b1);
    assign rf_rdata = rf_model(rf_addr, rf_mmd);

    mdio_c45_responder #(.PRE_LEN(32), .NUM_MMD(NUM_MMD)) u_dut (
        .mdc            (mdc),
        .rst_n          (rst_n),
        .phy_addr_strap (STRAP),
        .mdio_i         (line),
        .mdio_o         (mdio_o),
        .mdio_oe        (mdio_oe),
        .rf_we          (rf_we),
        .rf_re          (rf_re),
        .rf_mmd         (rf_mmd),
        .rf_addr        (rf_addr),
        .rf_wdata       (rf_wdata),
        .rf_rdata       (rf_rdata)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    int          we_cnt = 0, re_cnt = 0, oe_cnt = 0;
    logic [15:0] mon_wdata, mon_waddr;
    logic [4:0]  mon_wmmd;

    always @(negedge mdc) begin
        if (rf_we) begin
            we_cnt++;
            mon_wdata = rf_wdata;
            mon_waddr = rf_addr;
            mon_wmmd  = rf_mmd;
        end
        if (rf_re) re_cnt++;
        if (mdio_oe) oe_cnt++;
    end

    logic [17:0] rd_bits;
    logic        ta1_oe;

    task automatic drive_bit(logic b);
        @(negedge mdc);
        host_oe  = 1'b1;
        host_val = b;
    endtask

    task automatic send_frame(int npre, logic [1:0] st, logic [1:0] op, logic [4:0] phy,
                              logic [4:0] mmd, logic [1:0] ta, logic [15:0] data);
        we_cnt = 0; re_cnt = 0; oe_cnt = 0;
        rd_bits = '1; ta1_oe = 1'b0;
        drive_bit(1'b0);
        repeat (npre) drive_bit(1'b1);
        drive_bit(st[1]); drive_bit(st[0]);
        drive_bit(op[1]); drive_bit(op[0]);
        for (int i = 4; i >= 0; i--) drive_bit(phy[i]);
        for (int i = 4; i >= 0; i--) drive_bit(mmd[i]);
        if (op[1]) begin
            @(negedge mdc);
            host_oe = 1'b0;
            ta1_oe  = mdio_oe;
            for (int i = 0; i < 18; i++) begin
                @(negedge mdc);
                rd_bits[17-i] = line;
            end
        end else begin
            drive_bit(ta[1]); drive_bit(ta[0]);
            for (int i = 15; i >= 0; i--) drive_bit(data[i]);
        end
        @(negedge mdc);
        host_oe = 1'b0;
        repeat (3) @(negedge mdc);
    endtask

    function automatic string tag_of(logic [1:0] op, logic [4:0] phy, logic [4:0] mmd,
                                     logic [1:0] ta);
        if (phy != STRAP) return "R3";
        if (32'(mmd) >= NUM_MMD) return "R4";
        case (op)
            2'b00:   return (ta == 2'b10) ? "R4" : "R9";
            2'b01:   return (ta == 2'b10) ? "R5" : "R9";
            2'b11:   return "R6";
            default: return "R10";
        endcase
    endfunction

    logic [15:0] mdl_ptr [32];

    initial begin
        for (int i = 0; i < 32; i++) mdl_ptr[i] = '0;
        repeat (4) @(posedge mdc);
        @(negedge mdc);
        rst_n = 1'b1;
        @(negedge mdc);

        // R11 reset state at the ports
        check("R11", "oe after reset", mdio_oe, 0);
        check("R11", "we after reset", rf_we, 0);
        check("R11", "re after reset", rf_re, 0);
        check("R11", "mmd after reset", rf_mmd, 0);
        check("R11", "pointer after reset", rf_addr, 0);

        // R11 untouched MMD pointer is zero
        send_frame(32, 2'b00, 2'b01, STRAP, 5'd2, 2'b10, 16'h00AA);
        check("R11", "we count", we_cnt, 1);
        check("R11", "pointer of fresh MMD", mon_waddr, 0);

        // R1 one bit short of a preamble
        send_frame(31, 2'b00, 2'b01, STRAP, 5'd2, 2'b10, 16'h0101);
        check("R1", "31 ones accepted", we_cnt, 0);

        // R1 broken run of ones
        repeat (20) drive_bit(1'b1);
        send_frame(20, 2'b00, 2'b01, STRAP, 5'd2, 2'b10, 16'h0202);
        check("R1", "broken run accepted", we_cnt, 0);

        // R1 longer preamble still valid
        send_frame(40, 2'b00, 2'b01, STRAP, 5'd2, 2'b10, 16'h0303);
        check("R1", "long preamble write", we_cnt, 1);
        check("R1", "long preamble data", mon_wdata, 16'h0303);

        // R2 bad start pair, then a clean frame
        send_frame(32, 2'b01, 2'b01, STRAP, 5'd2, 2'b10, 16'h0404);
        check("R2", "bad start accepted", we_cnt, 0);
        send_frame(32, 2'b00, 2'b01, STRAP, 5'd2, 2'b10, 16'h0505);
        check("R2", "resync write", we_cnt, 1);

        // Table walk against a bench model of the pointers
        for (int v = 0; v < NV; v++) begin
            logic [1:0]  op;
            logic [4:0]  phy, mmd;
            logic [1:0]  ta;
            logic [15:0] dat;
            logic        hit, exp_we, exp_rd;
            string       tg;
            {op, phy, mmd, ta, dat} = VEC[v];
            hit    = (phy == STRAP) && (32'(mmd) < NUM_MMD);
            exp_we = hit && (op == 2'b01) && (ta == 2'b10);
            exp_rd = hit && (op == 2'b11);
            tg     = tag_of(op, phy, mmd, ta);
            send_frame(32, 2'b00, op, phy, mmd, ta, dat);
            check(tg, "we count", we_cnt, 32'(exp_we));
            if (exp_we) begin
                check(tg, "write data", mon_wdata, dat);
                check(tg, "write pointer", mon_waddr, mdl_ptr[mmd]);
                check(tg, "write mmd", mon_wmmd, mmd);
            end
            check(tg, "re count", re_cnt, 32'(exp_rd));
            check("R7", "oe bit times", oe_cnt, exp_rd ? 17 : 0);
            if (op[1]) begin
                check("R6", "first turnaround driven", ta1_oe, 0);
                check(tg, "line during read", rd_bits,
                      exp_rd ? {14'd0, 1'b0, rf_model(mdl_ptr[mmd], mmd), 1'b1}
                             : 32'h3FFFF);
            end
            if (hit && (op == 2'b00) && (ta == 2'b10)) mdl_ptr[mmd] = dat;
        end

        // R8 pointer unchanged by prior reads and writes
        send_frame(32, 2'b00, 2'b01, STRAP, 5'd1, 2'b10, 16'h9999);
        check("R8", "pointer after accesses", mon_waddr, 16'h1234);
        send_frame(32, 2'b00, 2'b01, STRAP, 5'd1, 2'b10, 16'h8888);
        check("R8", "pointer after second write", mon_waddr, 16'h1234);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge mdc);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule